// File: doc/BRIEF.md
# Erased-Page ECC Failure Filter

This block sits after the ECC decoder of a flash read path. While a page streams past it, byte by byte over the main area and then the spare area, it counts the zero bits. In the same window it collects the decoder's per-region results: one uncorrectable flag and one corrected-bit count for each 512-byte data region. A freshly erased page reads as all ones, and the decoder cannot tell it from a damaged page, so it reports it as uncorrectable. The filter therefore overrides that result when the whole page, spare bytes included, holds no more zero bits than a programmable limit. A small number of flipped bits in an erased page is tolerated that way.

One cycle after the final byte of the page, the block presents its verdict and holds it until the next start pulse. The verdict is one of clean, erased or failed. With it come the page's total corrected-bit count and the largest count seen in any one region. Two saturating running statistics follow the page results. One accumulates the reported corrected bits and the other counts failed pages. Results for a page are only accepted between its start pulse and its final byte.

Top module: `erased_page_filter`

## Requirements
- R1: After reset, done, page_ok, page_erased, page_failed, corr_total, corr_max, stat_corrected and stat_failures are all zero.
- R2: A page consists of REGIONS*REGION_BYTES main bytes followed by SPARE_BYTES spare bytes, counted over cycles with byte_valid high (idle cycles are allowed). done rises in the cycle after the final byte is accepted and holds with all verdict outputs unchanged until start. The cycle after start, done is 0.
- R3: If no accepted region result has region_uncorr=1, the verdict is page_ok=1, page_erased=0 and page_failed=0. corr_total is the sum of the region counts and corr_max is their maximum.
- R4: If some region is uncorrectable and the zero bits of the whole page are at most zero_limit, the verdict is page_ok=1 and page_erased=1, with corr_total=0 and corr_max=0.
- R5: Zero bits in the spare bytes count toward the limit. An uncorrectable page whose main bytes are all ones but whose spare bytes hold more zeros than zero_limit fails.
- R6: If some region is uncorrectable and the zeros exceed zero_limit, the verdict is page_failed=1 and page_ok=0, with the decoder's sum and maximum reported. stat_failures increments by one.
- R7: At every verdict, stat_corrected adds the reported corr_total and saturates at all ones.
- R8: stat_failures saturates at all ones and never wraps.
- R9: Bytes and region results arriving before the first start or after a page's final byte, and region results beyond REGIONS per page, have no effect on any output.
- R10: The limit comparison is inclusive. Zeros equal to zero_limit give an erased verdict, and one more gives a failed verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a new page and clears the previous verdict |
| byte_valid | input | 1 | byte_data carries a page byte this cycle |
| byte_data | input | 8 | Page byte, main area first, then spare |
| region_valid | input | 1 | A decoder region result is present this cycle |
| region_uncorr | input | 1 | The region was uncorrectable |
| region_bits | input | CNT_W | Bits corrected in the region |
| zero_limit | input | ZCNT_W | Largest zero-bit count still taken as erased |
| done | output | 1 | Verdict valid |
| page_ok | output | 1 | Page accepted (clean or erased) |
| page_erased | output | 1 | Page accepted as erased |
| page_failed | output | 1 | Page uncorrectable |
| corr_total | output | SUM_W | Corrected bits reported for the page |
| corr_max | output | CNT_W | Largest corrected count of any region |
| stat_corrected | output | STAT_W | Saturating running sum of corr_total |
| stat_failures | output | STAT_W | Saturating count of failed pages |

## Verification
The assertions assume that start never coincides with byte_valid and that zero_limit stays constant while a page is open. They also assume that the decoder delivers each region result no later than the page's final byte. The stimulus keeps to this in every case. Each page opens with an isolated start pulse, the limit changes only between pages, and the region results are driven together with the last byte of their region. Traffic outside an open page is sent on purpose, to confirm that it is ignored.

// File: rtl/epf_pkg.sv
package epf_pkg;

   typedef enum logic [1:0] {
      VERD_NONE  = 2'd0,
      VERD_CLEAN = 2'd1,
      VERD_BLANK = 2'd2,
      VERD_BAD   = 2'd3
   } verdict_e;

   // number of zero bits in one byte
   function automatic logic [3:0] zeros_in_byte(input logic [7:0] b);
      logic [3:0] n;
      n = '0;
      for (int i = 0; i < 8; i++) n = n + {3'b000, ~b[i]};
      return n;
   endfunction

endpackage

// File: rtl/epf_zero_counter.sv
module epf_zero_counter #(
   parameter int PAGE_BYTES = 2112,
   parameter int ZCNT_W     = 15,
   parameter bit POP_TREE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   output logic              open_o,
   output logic              last_hit,
   output logic [ZCNT_W-1:0] zero_nxt
);
   import epf_pkg::*;

   localparam int BCNT_W = $clog2(PAGE_BYTES + 1);
   localparam logic [BCNT_W-1:0] LAST_IDX = BCNT_W'(PAGE_BYTES - 1);

   logic [BCNT_W-1:0] bcnt;
   logic [ZCNT_W-1:0] zacc;
   logic [3:0]        zb;
   logic              take;

   generate
      if (POP_TREE) begin : g_tree
         logic [1:0] p0, p1, p2, p3;
         logic [2:0] q0, q1;
         always_comb begin
            p0 = {1'b0, ~byte_data[0]} + {1'b0, ~byte_data[1]};
            p1 = {1'b0, ~byte_data[2]} + {1'b0, ~byte_data[3]};
            p2 = {1'b0, ~byte_data[4]} + {1'b0, ~byte_data[5]};
            p3 = {1'b0, ~byte_data[6]} + {1'b0, ~byte_data[7]};
            q0 = {1'b0, p0} + {1'b0, p1};
            q1 = {1'b0, p2} + {1'b0, p3};
            zb = {1'b0, q0} + {1'b0, q1};
         end
      end else begin : g_serial
         always_comb zb = zeros_in_byte(byte_data);
      end
   endgenerate

   assign take     = byte_valid && open_o && !start;
   assign last_hit = take && (bcnt == LAST_IDX);
   assign zero_nxt = take ? (zacc + ZCNT_W'(zb)) : zacc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_o <= 1'b0;
         bcnt   <= '0;
         zacc   <= '0;
      end else if (start) begin
         open_o <= 1'b1;
         bcnt   <= '0;
         zacc   <= '0;
      end else if (take) begin
         bcnt <= bcnt + 1'b1;
         zacc <= zero_nxt;
         if (last_hit) open_o <= 1'b0;
      end
   end

   // R2: byte index never runs past the final byte of the page
   assert_byte_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
      open_o |-> bcnt <= LAST_IDX);

   // R9: a closed page accumulates nothing
   assert_closed_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_o && !start) |=> $stable(zacc) && $stable(bcnt));

   // R2: the page closes right after its final byte
   assert_close_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
      last_hit |=> !open_o);

endmodule

// File: rtl/epf_region_stats.sv
module epf_region_stats #(
   parameter int REGIONS = 4,
   parameter int CNT_W   = 6,
   parameter int SUM_W   = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             open_i,
   input  logic             region_valid,
   input  logic             region_uncorr,
   input  logic [CNT_W-1:0] region_bits,
   output logic [SUM_W-1:0] sum_nxt,
   output logic [CNT_W-1:0] max_nxt,
   output logic             unc_nxt
);
   localparam int RCNT_W = $clog2(REGIONS + 1);
   localparam logic [RCNT_W-1:0] REG_LIM = RCNT_W'(REGIONS);

   logic [RCNT_W-1:0] rcnt;
   logic [SUM_W-1:0]  sm;
   logic [CNT_W-1:0]  mx;
   logic              unc;
   logic              take;

   assign take    = region_valid && open_i && !start && (rcnt < REG_LIM);
   assign sum_nxt = take ? (sm + SUM_W'(region_bits)) : sm;
   assign max_nxt = (take && (region_bits > mx)) ? region_bits : mx;
   assign unc_nxt = unc | (take & region_uncorr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt <= '0;
         sm   <= '0;
         mx   <= '0;
         unc  <= 1'b0;
      end else if (start) begin
         rcnt <= '0;
         sm   <= '0;
         mx   <= '0;
         unc  <= 1'b0;
      end else if (take) begin
         rcnt <= rcnt + 1'b1;
         sm   <= sum_nxt;
         mx   <= max_nxt;
         unc  <= unc_nxt;
      end
   end

   // R3: the largest region count never exceeds the page sum
   assert_max_le_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
      SUM_W'(mx) <= sm);

   // R9: no more than REGIONS results are taken per page
   assert_region_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rcnt <= REG_LIM);

endmodule

// File: rtl/epf_sat_counter.sv
module epf_sat_counter #(
   parameter int W     = 16,
   parameter int INC_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_en,
   input  logic [INC_W-1:0] inc_val,
   output logic [W-1:0]     cnt
);
   localparam int WW = ((W > INC_W) ? W : INC_W) + 1;
   localparam logic [WW-1:0] TOP = WW'({W{1'b1}});

   logic [WW-1:0] wide;

   assign wide = WW'(cnt) + WW'(inc_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (inc_en)
         cnt <= (wide > TOP) ? {W{1'b1}} : wide[W-1:0];
   end

   // R7 / R8: a saturated counter stays saturated
   assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (&cnt) |=> (&cnt));

   // R8: the counter never goes down
   assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cnt >= $past(cnt));

endmodule

// File: rtl/erased_page_filter.sv
module erased_page_filter #(
   parameter int REGION_BYTES = 512,
   parameter int REGIONS      = 4,
   parameter int SPARE_BYTES  = 64,
   parameter int CNT_W        = 6,
   parameter int SUM_W        = 9,
   parameter int ZCNT_W       = 15,
   parameter int STAT_W       = 16,
   parameter bit POP_TREE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   input  logic              region_valid,
   input  logic              region_uncorr,
   input  logic [CNT_W-1:0]  region_bits,
   input  logic [ZCNT_W-1:0] zero_limit,
   output logic              done,
   output logic              page_ok,
   output logic              page_erased,
   output logic              page_failed,
   output logic [SUM_W-1:0]  corr_total,
   output logic [CNT_W-1:0]  corr_max,
   output logic [STAT_W-1:0] stat_corrected,
   output logic [STAT_W-1:0] stat_failures
);
   import epf_pkg::*;

   localparam int PAGE_BYTES = REGIONS * REGION_BYTES + SPARE_BYTES;
   localparam int ZCNT_MIN   = $clog2(PAGE_BYTES * 8 + 1);
   localparam int SUM_MIN    = CNT_W + $clog2(REGIONS + 1);

   generate
      if (REGIONS < 1 || REGION_BYTES < 1 || SPARE_BYTES < 0) begin : g_bad_geom
         $error("erased_page_filter: page geometry parameters out of range");
      end
      if (ZCNT_W < ZCNT_MIN) begin : g_bad_zcnt
         $error("erased_page_filter: ZCNT_W too narrow for the page");
      end
      if (SUM_W < SUM_MIN) begin : g_bad_sum
         $error("erased_page_filter: SUM_W too narrow for REGIONS counts");
      end
      if (STAT_W < 1 || CNT_W < 1) begin : g_bad_stat
         $error("erased_page_filter: counter widths must be positive");
      end
   endgenerate

   logic              open_w;
   logic              last_hit;
   logic [ZCNT_W-1:0] zero_nxt;
   logic [SUM_W-1:0]  sum_nxt;
   logic [CNT_W-1:0]  max_nxt;
   logic              unc_nxt;
   verdict_e          verd_q;
   verdict_e          verd_nxt;
   logic [SUM_W-1:0]  rep_total;
   logic [CNT_W-1:0]  rep_max;

   epf_zero_counter #(
      .PAGE_BYTES(PAGE_BYTES),
      .ZCNT_W    (ZCNT_W),
      .POP_TREE  (POP_TREE)
   ) u_zeros (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .byte_valid(byte_valid),
      .byte_data (byte_data),
      .open_o    (open_w),
      .last_hit  (last_hit),
      .zero_nxt  (zero_nxt)
   );

   epf_region_stats #(
      .REGIONS(REGIONS),
      .CNT_W  (CNT_W),
      .SUM_W  (SUM_W)
   ) u_regions (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .open_i       (open_w),
      .region_valid (region_valid),
      .region_uncorr(region_uncorr),
      .region_bits  (region_bits),
      .sum_nxt      (sum_nxt),
      .max_nxt      (max_nxt),
      .unc_nxt      (unc_nxt)
   );

   always_comb begin
      if (!unc_nxt)
         verd_nxt = VERD_CLEAN;
      else if (zero_nxt <= zero_limit)
         verd_nxt = VERD_BLANK;
      else
         verd_nxt = VERD_BAD;
      rep_total = (verd_nxt == VERD_BLANK) ? '0 : sum_nxt;
      rep_max   = (verd_nxt == VERD_BLANK) ? '0 : max_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         verd_q     <= VERD_NONE;
         corr_total <= '0;
         corr_max   <= '0;
      end else if (start) begin
         verd_q     <= VERD_NONE;
         corr_total <= '0;
         corr_max   <= '0;
      end else if (last_hit) begin
         verd_q     <= verd_nxt;
         corr_total <= rep_total;
         corr_max   <= rep_max;
      end
   end

   assign done        = (verd_q != VERD_NONE);
   assign page_ok     = (verd_q == VERD_CLEAN) || (verd_q == VERD_BLANK);
   assign page_erased = (verd_q == VERD_BLANK);
   assign page_failed = (verd_q == VERD_BAD);

   epf_sat_counter #(
      .W    (STAT_W),
      .INC_W(SUM_W)
   ) u_stat_corr (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_en (last_hit),
      .inc_val(rep_total),
      .cnt    (stat_corrected)
   );

   epf_sat_counter #(
      .W    (STAT_W),
      .INC_W(1)
   ) u_stat_fail (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_en (last_hit && (verd_nxt == VERD_BAD)),
      .inc_val(1'b1),
      .cnt    (stat_failures)
   );

   // R2: verdict appears in the cycle after the final byte
   assert_verdict_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      last_hit |=> done);

   // R2: verdict holds until the next start
   assert_verdict_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done && $stable(corr_total) && $stable(corr_max)
                           && $stable(page_failed) && $stable(page_erased));

   // R2: start withdraws the verdict
   assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done);

   // R4: an erased page is accepted with zero corrected bits
   assert_blank_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      page_erased |-> page_ok && (corr_total == '0) && (corr_max == '0));

   // R6: every new failure moves the failure statistic
   assert_fail_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(page_failed) |-> (stat_failures == $past(stat_failures) + 1'b1)
                             || (&stat_failures));

   // R6: a failed page is never also accepted
   assert_fail_not_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
      page_failed |-> !page_ok && !page_erased);

endmodule

// File: tb/test_erased_page_filter.sv
`timescale 1ns/1ps
module test_erased_page_filter;
   localparam int RB    = 512;
   localparam int NREG  = 2;
   localparam int SPARE = 16;
   localparam int MAIN  = NREG * RB;
   localparam int PAGE  = MAIN + SPARE;
   localparam int CW    = 6;
   localparam int SW    = 8;
   localparam int ZW    = 14;
   localparam int STW   = 4;
   localparam int STMAX = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic byte_valid = 1'b0;
   logic [7:0] byte_data = 8'hFF;
   logic region_valid = 1'b0;
   logic region_uncorr = 1'b0;
   logic [CW-1:0] region_bits = '0;
   logic [ZW-1:0] zero_limit = '0;
   logic done, page_ok, page_erased, page_failed;
   logic [SW-1:0] corr_total;
   logic [CW-1:0] corr_max;
   logic [STW-1:0] stat_corrected, stat_failures;

   int checks = 0;
   int failures = 0;
   bit ended = 1'b0;

   always #5 clk = ~clk;

   erased_page_filter #(
      .REGION_BYTES(RB), .REGIONS(NREG), .SPARE_BYTES(SPARE), .CNT_W(CW),
      .SUM_W(SW), .ZCNT_W(ZW), .STAT_W(STW), .POP_TREE(1'b1)
   ) i_erased_page_filter (
      .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
      .byte_data(byte_data), .region_valid(region_valid),
      .region_uncorr(region_uncorr), .region_bits(region_bits),
      .zero_limit(zero_limit), .done(done), .page_ok(page_ok),
      .page_erased(page_erased), .page_failed(page_failed),
      .corr_total(corr_total), .corr_max(corr_max),
      .stat_corrected(stat_corrected), .stat_failures(stat_failures)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit m_open, m_unc, m_done, m_ok, m_er, m_fail;
   int m_cnt, m_zero, m_rcnt, m_sum, m_max, m_tot, m_mx, m_sc, m_sf;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_open = 0; m_unc = 0; m_done = 0; m_ok = 0; m_er = 0; m_fail = 0;
         m_cnt = 0; m_zero = 0; m_rcnt = 0; m_sum = 0; m_max = 0;
         m_tot = 0; m_mx = 0; m_sc = 0; m_sf = 0;
      end else if (start) begin
         m_open = 1; m_unc = 0; m_done = 0; m_ok = 0; m_er = 0; m_fail = 0;
         m_cnt = 0; m_zero = 0; m_rcnt = 0; m_sum = 0; m_max = 0;
         m_tot = 0; m_mx = 0;
      end else if (m_open) begin
         if (region_valid && m_rcnt < NREG) begin
            m_rcnt++;
            m_sum += int'(region_bits);
            if (int'(region_bits) > m_max) m_max = int'(region_bits);
            if (region_uncorr) m_unc = 1;
         end
         if (byte_valid) begin
            m_zero += 8 - $countones(byte_data);
            m_cnt++;
            if (m_cnt == PAGE) begin
               m_open = 0;
               m_done = 1;
               m_er   = m_unc && (m_zero <= int'(zero_limit));
               m_fail = m_unc && !m_er;
               m_ok   = !m_fail;
               m_tot  = m_er ? 0 : m_sum;
               m_mx   = m_er ? 0 : m_max;
               m_sc   = (m_sc + m_tot > STMAX) ? STMAX : m_sc + m_tot;
               if (m_fail) m_sf = (m_sf + 1 > STMAX) ? STMAX : m_sf + 1;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !ended) begin
         chk("R2 model done", done, m_done);
         chk("R3 model page_ok", page_ok, m_ok);
         chk("R4 model page_erased", page_erased, m_er);
         chk("R6 model page_failed", page_failed, m_fail);
         chk("R3 model corr_total", corr_total, m_tot);
         chk("R3 model corr_max", corr_max, m_mx);
         chk("R7 model stat_corrected", stat_corrected, m_sc);
         chk("R8 model stat_failures", stat_failures, m_sf);
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [7:0] zbyte(input int k);
      if (k <= 0) return 8'hFF;
      if (k >= 8) return 8'h00;
      return 8'(8'hFF << k);
   endfunction

   task automatic send_page(input int zm, input int zs, input bit u0, input bit u1,
                            input int c0, input int c1, input bit gap);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < PAGE; i++) begin
         if (gap && (i % 97 == 5)) begin
            byte_valid = 1'b0; region_valid = 1'b0;
            @(negedge clk);
         end
         byte_valid = 1'b1;
         byte_data  = (i < MAIN) ? zbyte(zm - 8 * i) : zbyte(zs - 8 * (i - MAIN));
         region_valid = 1'b0;
         if (i == RB - 1) begin
            region_valid = 1'b1; region_uncorr = u0; region_bits = CW'(c0);
         end
         if (i == 2 * RB - 1) begin
            region_valid = 1'b1; region_uncorr = u1; region_bits = CW'(c1);
         end
         if (i == PAGE - 1) chk("R2 no verdict before final byte", done, 0);
         @(negedge clk);
      end
      byte_valid = 1'b0; region_valid = 1'b0; region_uncorr = 1'b0;
   endtask

   task automatic exp_page(input string req, input bit ok, input bit er, input bit fl,
                           input int tot, input int mx);
      chk({req, " done"}, done, 1);
      chk({req, " page_ok"}, page_ok, ok);
      chk({req, " page_erased"}, page_erased, er);
      chk({req, " page_failed"}, page_failed, fl);
      chk({req, " corr_total"}, corr_total, tot);
      chk({req, " corr_max"}, corr_max, mx);
   endtask

   task automatic stray(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         byte_valid = 1'b1; byte_data = 8'h00;
         region_valid = 1'b1; region_uncorr = 1'b1; region_bits = CW'(33);
      end
      @(negedge clk);
      byte_valid = 1'b0; region_valid = 1'b0; region_uncorr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 done", done, 0);
      chk("R1 page_ok", page_ok, 0);
      chk("R1 page_failed", page_failed, 0);
      chk("R1 corr_total", corr_total, 0);
      chk("R1 stat_corrected", stat_corrected, 0);
      chk("R1 stat_failures", stat_failures, 0);

      // R9: traffic before any start is ignored
      stray(20);
      chk("R9 pre-start done", done, 0);
      chk("R9 pre-start stat_failures", stat_failures, 0);

      zero_limit = ZW'(4);
      // R3: clean page with data zeros, counts 3 and 5
      send_page(3000, 10, 0, 0, 3, 5, 0);
      exp_page("R3 clean", 1, 0, 0, 8, 5);
      chk("R7 stat after clean", stat_corrected, 8);

      // R9: traffic after the final byte is ignored
      stray(15);
      exp_page("R9 post-page hold", 1, 0, 0, 8, 5);
      chk("R9 post-page stat_failures", stat_failures, 0);

      // R4: erased page with a few flips
      send_page(2, 1, 1, 0, 0, 2, 0);
      exp_page("R4 erased", 1, 1, 0, 0, 0);
      chk("R7 erased adds nothing", stat_corrected, 8);

      // R5: zeros only in spare, above the limit
      send_page(0, 6, 0, 1, 1, 0, 0);
      exp_page("R5 spare zeros fail", 0, 0, 1, 1, 1);
      chk("R6 failures after first fail", stat_failures, 1);

      // R10: exactly at limit -> erased, one above -> failed
      send_page(4, 0, 1, 1, 2, 2, 0);
      exp_page("R10 at limit", 1, 1, 0, 0, 0);
      send_page(3, 2, 1, 0, 2, 1, 0);
      exp_page("R10 above limit", 0, 0, 1, 3, 2);
      chk("R6 failures after second fail", stat_failures, 2);

      // R2: page with idle gaps, start clears verdict
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      chk("R2 start clears done", done, 0);
      send_page(5000, 40, 0, 0, 0, 1, 1);
      exp_page("R2 gapped clean", 1, 0, 0, 1, 1);

      // R7 / R8: saturation under repeated failing pages
      for (int p = 0; p < 15; p++) send_page(100, 0, 1, 0, 4, 4, 0);
      exp_page("R6 failing page", 0, 0, 1, 8, 4);
      chk("R7 stat_corrected saturated", stat_corrected, STMAX);
      chk("R8 stat_failures saturated", stat_failures, STMAX);
      send_page(100, 0, 1, 1, 4, 4, 0);
      chk("R8 stat_failures no wrap", stat_failures, STMAX);
      chk("R7 stat_corrected no wrap", stat_corrected, STMAX);

      repeat (3) @(negedge clk);
      finish_up();
   end
endmodule